// File: doc/BRIEF.md
# Timer and Inter-Processor Interrupt Control

This block holds one 64-bit control word that tracks, for each of four CPUs, a timer interrupt and an inter-processor interrupt (IPI). A periodic tick input marks every CPU as timer-interrupting. Software writes to the word do three things. They acknowledge timer interrupts. They send IPIs to any subset of CPUs. They acknowledge IPIs. Each CPU gets its own timer interrupt line and its own IPI line.

IPIs are counted rather than latched. Each CPU keeps a pending-send count, and its IPI line stays high until every send has been matched by an acknowledge, even after its IPI status bit already reads as zero. A read returns the word with its two lowest bits replaced by the identifier of the CPU that is reading. A write that names none of the control fields and does not carry the ignore marker is rejected with a one-cycle error pulse.

Field positions in the written and read word:

| Bits | Meaning |
|------|---------|
| 1:0 | identifier of the reading CPU |
| 7:4 | timer status, bit 4+i for CPU i |
| 11:8 | IPI status, bit 8+i for CPU i |
| 15:12 | IPI send, bit 12+i for CPU i |
| 28 | ignore marker |

A write is sampled on a rising clock edge, and its effect is visible after that edge.

Top module: `ipi_timer_ctl`

## Requirements
- R1: After reset the timer lines, the IPI lines and the error pulse are low. Every bit of the read word is zero except bits 1:0.
- R2: A tick sets timer status bit 4+i and raises the timer line of every CPU i. A CPU that is already interrupting stays interrupting.
- R3: Writing 1 to bit 4+i clears timer status bit 4+i and lowers CPU i's timer line.
- R4: A tick in the same cycle as a timer acknowledge for CPU i leaves CPU i interrupting.
- R5: Writing 1 to bit 12+i does three things: it sets IPI status bit 8+i, adds one to CPU i's pending count, and raises CPU i's IPI line.
- R6: Writing 1 to bit 8+i clears IPI status bit 8+i and, if CPU i's pending count is nonzero, subtracts one from it. CPU i's IPI line falls only when the count reaches zero.
- R7: All three fields of one write are applied in this order: timer acknowledge, then IPI send, then IPI acknowledge. A send and an acknowledge to the same CPU in one write leave its status bit at 0 and its count unchanged.
- R8: The pending count is 4 bits wide and saturates at 15. After 16 or more sends, exactly 15 acknowledges are needed to lower the IPI line.
- R9: A write carrying bit 28 is accepted. Bit 28 on its own changes no state and raises no error.
- R10: A write with bits 15:4 all zero and bit 28 clear changes no state. It drives the error output high for the one cycle after the write.
- R11: The read word returns the timer and IPI status bits at the positions given above, with bits 1:0 equal to the requesting CPU identifier and all other bits zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low synchronous reset |
| tick_i | input | 1 | periodic timer tick |
| wr_en_i | input | 1 | write strobe for the control word |
| wr_data_i | input | 64 | write data |
| rd_cpu_i | input | 2 | identifier of the requesting CPU |
| rd_data_o | output | 64 | read view of the control word |
| timer_irq_o | output | 4 | per-CPU timer interrupt lines |
| ipi_irq_o | output | 4 | per-CPU IPI lines |
| wr_err_o | output | 1 | one-cycle pulse after an unsupported write |

## Verification
The embedded assertions check the following on every cycle:
- a tick always leaves the timer line high, and an acknowledge without a tick lowers it;
- a send raises the IPI line, and the last acknowledge lowers it;
- a saturated count holds under further sends;
- an unsupported write leaves the status untouched and produces the error pulse.

Only the bench's scenarios can show the rest. These cover the counted behaviour over long send/acknowledge sequences, where the status bit reads zero while the line stays high. They also cover the ordering of fields within a single combined write and the exact read word for each requesting CPU.

// File: rtl/ipi_timer_pkg.sv
package ipi_timer_pkg;
    localparam int FIELD_W  = 4;
    localparam int TMR_LSB  = 4;
    localparam int IPI_LSB  = 8;
    localparam int SEND_LSB = 12;
    localparam int IGN_BIT  = 28;

    typedef struct packed {
        logic tmr_ack;
        logic ipi_send;
        logic ipi_ack;
    } lane_cmd_t;
endpackage

// File: rtl/ipi_timer_wr_decode.sv
module ipi_timer_wr_decode
    import ipi_timer_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int DATA_W  = 64
) (
    input  logic                        wr_en_i,
    input  logic [DATA_W-1:0]           wr_data_i,
    output lane_cmd_t [NUM_CPU-1:0]     cmd_o,
    output logic                        unsup_o
);
    localparam int CTRL_HI = SEND_LSB + FIELD_W - 1;

    logic any_field;
    logic accepted;
    logic unused_bits;

    assign unused_bits = ^wr_data_i;
    assign any_field   = |wr_data_i[CTRL_HI:TMR_LSB];
    assign accepted    = wr_en_i && (any_field || wr_data_i[IGN_BIT]);
    assign unsup_o     = wr_en_i && !any_field && !wr_data_i[IGN_BIT];

    for (genvar i = 0; i < NUM_CPU; i++) begin : g_cmd
        assign cmd_o[i].tmr_ack  = accepted && wr_data_i[TMR_LSB + i];
        assign cmd_o[i].ipi_send = accepted && wr_data_i[SEND_LSB + i];
        assign cmd_o[i].ipi_ack  = accepted && wr_data_i[IPI_LSB + i];
    end
endmodule

// File: rtl/ipi_timer_lane.sv
module ipi_timer_lane
    import ipi_timer_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      tick_i,
    input  lane_cmd_t cmd_i,
    output logic      tmr_irq_o,
    output logic      ipi_stat_o,
    output logic      ipi_irq_o
);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;

    typedef struct packed {
        logic             tmr;
        logic             ipi_st;
        logic [CNT_W-1:0] cnt;
    } lane_state_t;

    lane_state_t lane_d, lane_q;

    always_comb begin
        lane_d = lane_q;
        // timer acknowledge first, a tick in the same cycle wins
        if (cmd_i.tmr_ack) lane_d.tmr = 1'b0;
        if (tick_i)        lane_d.tmr = 1'b1;
        // send before acknowledge
        if (cmd_i.ipi_send) begin
            lane_d.ipi_st = 1'b1;
            if (lane_d.cnt != CNT_MAX) lane_d.cnt = lane_d.cnt + 1'b1;
        end
        if (cmd_i.ipi_ack) begin
            lane_d.ipi_st = 1'b0;
            if (lane_d.cnt != CNT_ZERO) lane_d.cnt = lane_d.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) lane_q <= '0;
        else         lane_q <= lane_d;
    end

    assign tmr_irq_o  = lane_q.tmr;
    assign ipi_stat_o = lane_q.ipi_st;
    assign ipi_irq_o  = (lane_q.cnt != CNT_ZERO);

    p_tick_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_i |=> tmr_irq_o);
    p_ack_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_i.tmr_ack && !tick_i |=> !tmr_irq_o);
    p_send_raises_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_i.ipi_send && !cmd_i.ipi_ack |=> ipi_irq_o);
    p_last_ack_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lane_q.cnt == 1) && cmd_i.ipi_ack && !cmd_i.ipi_send |=> !ipi_irq_o);
    p_ack_status_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_i.ipi_ack |=> !ipi_stat_o);
    p_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lane_q.cnt == CNT_MAX) && cmd_i.ipi_send && !cmd_i.ipi_ack
        |=> lane_q.cnt == CNT_MAX);
endmodule

// File: rtl/ipi_timer_ctl.sv
module ipi_timer_ctl
    import ipi_timer_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int DATA_W  = 64,
    parameter int CNT_W   = 4,
    parameter int ID_W    = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ID_W-1:0]   rd_cpu_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [NUM_CPU-1:0] timer_irq_o,
    output logic [NUM_CPU-1:0] ipi_irq_o,
    output logic              wr_err_o
);
    typedef struct packed {
        logic err;
    } top_state_t;

    lane_cmd_t [NUM_CPU-1:0] cmd;
    logic                    unsup;
    logic [NUM_CPU-1:0]      tmr_stat;
    logic [NUM_CPU-1:0]      ipi_stat;
    top_state_t              top_d, top_q;

    ipi_timer_wr_decode #(
        .NUM_CPU (NUM_CPU),
        .DATA_W  (DATA_W)
    ) u_dec (
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .cmd_o     (cmd),
        .unsup_o   (unsup)
    );

    for (genvar i = 0; i < NUM_CPU; i++) begin : g_lane
        ipi_timer_lane #(
            .CNT_W (CNT_W)
        ) u_lane (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .tick_i     (tick_i),
            .cmd_i      (cmd[i]),
            .tmr_irq_o  (tmr_stat[i]),
            .ipi_stat_o (ipi_stat[i]),
            .ipi_irq_o  (ipi_irq_o[i])
        );
    end

    always_comb begin
        top_d     = top_q;
        top_d.err = unsup;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) top_q <= '0;
        else         top_q <= top_d;
    end

    always_comb begin
        rd_data_o = '0;
        rd_data_o[ID_W-1:0] = rd_cpu_i;
        for (int i = 0; i < NUM_CPU; i++) begin
            rd_data_o[TMR_LSB + i] = tmr_stat[i];
            rd_data_o[IPI_LSB + i] = ipi_stat[i];
        end
    end

    assign timer_irq_o = tmr_stat;
    assign wr_err_o    = top_q.err;

    p_unsup_err_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i && (wr_data_i[15:4] == '0) && !wr_data_i[IGN_BIT] |=> wr_err_o);
    p_unsup_stable_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        unsup && !tick_i |=> $stable(tmr_stat) && $stable(ipi_stat) && $stable(ipi_irq_o));
    p_ignore_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i && wr_data_i[IGN_BIT] |=> !wr_err_o);
endmodule

// File: tb/ipi_timer_ctl_tb.sv
module ipi_timer_ctl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic [1:0]  rd_cpu = '0;
    logic [63:0] rd_data;
    logic [3:0]  timer_irq;
    logic [3:0]  ipi_irq;
    logic        wr_err;

    int    checks = 0;
    int    failures = 0;
    string cur_req = "R1";

    int m_tmr[4];
    int m_st[4];
    int m_cnt[4];
    int m_err = 0;

    always #10 clk = ~clk;

    ipi_timer_ctl dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .tick_i      (tick),
        .wr_en_i     (wr_en),
        .wr_data_i   (wr_data),
        .rd_cpu_i    (rd_cpu),
        .rd_data_o   (rd_data),
        .timer_irq_o (timer_irq),
        .ipi_irq_o   (ipi_irq),
        .wr_err_o    (wr_err)
    );

    task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        logic [63:0] e_rd;
        logic [3:0]  e_t;
        logic [3:0]  e_i;
        e_rd = '0;
        e_rd[1:0] = rd_cpu;
        for (int i = 0; i < 4; i++) begin
            e_rd[4 + i] = (m_tmr[i] != 0);
            e_rd[8 + i] = (m_st[i] != 0);
            e_t[i] = (m_tmr[i] != 0);
            e_i[i] = (m_cnt[i] > 0);
        end
        check("rd_data", rd_data, e_rd);
        check("timer_irq", {60'd0, timer_irq}, {60'd0, e_t});
        check("ipi_irq", {60'd0, ipi_irq}, {60'd0, e_i});
        check("wr_err", {63'd0, wr_err}, {63'd0, m_err[0]});
    endtask

    task automatic step(input logic t, input logic we, input logic [63:0] d, input logic [1:0] c);
        bit sup;
        tick = t; wr_en = we; wr_data = d; rd_cpu = c;
        @(posedge clk);
        sup = (d[15:4] != 0) || d[28];
        m_err = (we && !sup) ? 1 : 0;
        if (we && sup) begin
            for (int i = 0; i < 4; i++) begin
                if (d[4 + i]) m_tmr[i] = 0;
                if (d[12 + i]) begin
                    m_st[i] = 1;
                    if (m_cnt[i] < 15) m_cnt[i] = m_cnt[i] + 1;
                end
                if (d[8 + i]) begin
                    m_st[i] = 0;
                    if (m_cnt[i] > 0) m_cnt[i] = m_cnt[i] - 1;
                end
            end
        end
        if (t) for (int i = 0; i < 4; i++) m_tmr[i] = 1;
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr(input logic [63:0] d);
        step(1'b0, 1'b1, d, 2'd0);
    endtask

    task automatic idle();
        step(1'b0, 1'b0, 64'd0, 2'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_tmr[i] = 0; m_st[i] = 0; m_cnt[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        cur_req = "R1";
        compare_all();
        rd_cpu = 2'd3; #1;
        compare_all();

        // R2: tick raises every CPU, repeat tick keeps it
        cur_req = "R2";
        step(1'b1, 1'b0, 64'd0, 2'd1);
        check("timer_irq all", {60'd0, timer_irq}, 64'hF);
        step(1'b1, 1'b0, 64'd0, 2'd2);

        // R3: acknowledge CPUs 1 and 3
        cur_req = "R3";
        wr(64'h0000_00A0);
        check("timer_irq after ack", {60'd0, timer_irq}, 64'h5);
        wr(64'h0000_0010);

        // R4: tick with acknowledge of CPU 0 in the same cycle
        cur_req = "R4";
        step(1'b1, 1'b1, 64'h0000_0010, 2'd0);
        check("timer_irq cpu0 kept", {63'd0, timer_irq[0]}, 64'd1);
        wr(64'h0000_00F0);

        // R5: send to CPUs 0 and 2, then CPU 0 again
        cur_req = "R5";
        wr(64'h0000_5000);
        check("ipi_irq after send", {60'd0, ipi_irq}, 64'h5);
        wr(64'h0000_1000);

        // R6: first acknowledge clears status, line stays high
        cur_req = "R6";
        wr(64'h0000_0100);
        check("ipi status cpu0", {63'd0, rd_data[8]}, 64'd0);
        check("ipi line cpu0 held", {63'd0, ipi_irq[0]}, 64'd1);
        wr(64'h0000_0100);
        check("ipi line cpu0 dropped", {63'd0, ipi_irq[0]}, 64'd0);
        wr(64'h0000_0400);
        wr(64'h0000_0200);
        idle();

        // R7: combined write, send and acknowledge to CPU 1 together
        cur_req = "R7";
        step(1'b1, 1'b0, 64'd0, 2'd0);
        wr(64'h0000_2220);
        check("cpu1 status after combined", {63'd0, rd_data[9]}, 64'd0);
        check("cpu1 line after combined", {63'd0, ipi_irq[1]}, 64'd0);
        wr(64'h0000_2000);
        wr(64'h0000_2200);
        check("cpu1 line held", {63'd0, ipi_irq[1]}, 64'd1);
        wr(64'h0000_00F2);

        // R8: saturate CPU 3 with 20 sends, 15 acks needed
        cur_req = "R8";
        for (int k = 0; k < 20; k++) wr(64'h0000_8000);
        for (int k = 0; k < 14; k++) wr(64'h0000_0800);
        check("cpu3 line after 14 acks", {63'd0, ipi_irq[3]}, 64'd1);
        wr(64'h0000_0800);
        check("cpu3 line after 15 acks", {63'd0, ipi_irq[3]}, 64'd0);
        wr(64'h0000_0800);

        // R9: ignore marker alone, then with a send
        cur_req = "R9";
        wr(64'h1000_0000);
        idle();
        wr(64'h1000_4000);
        wr(64'h0000_0400);

        // R10: unsupported writes
        cur_req = "R10";
        wr(64'h0000_8000);
        step(1'b1, 1'b0, 64'd0, 2'd0);
        wr(64'h0000_0003);
        check("wr_err pulse", {63'd0, wr_err}, 64'd1);
        wr(64'hFFFF_FFFF_EFFF_000F);
        idle();
        check("wr_err low", {63'd0, wr_err}, 64'd0);
        wr(64'h0000_0800);

        // R11: read view for every requesting CPU
        cur_req = "R11";
        for (int c = 0; c < 4; c++) step(1'b0, 1'b0, 64'd0, c[1:0]);
        wr(64'h0000_00F0);
        idle();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule